// File: doc/BRIEF.md
# Prescaled Core Timer Counter

This block keeps the free-running time base used by per-core timer events. A stream of single-cycle tick enables comes in from one of two sources. A fractional prescaler thins that stream, and each surviving tick advances a wide counter by one or by two. The counter value is available on a port. A one-cycle strobe marks every cycle in which the counter moves, so downstream comparators can act on each advance.

Software sets up the block through a small word-addressed register port. A control word selects the tick source and the step size. A 32-bit prescale word sets the rate ratio: the counter rate equals the source tick rate times the prescale value divided by 2^31. The ratio is produced by a phase accumulator. Each accepted tick adds the prescale value to the accumulator, and a carry past 2^31 yields one counter step. The remainder is kept for the next tick. The counter can also be read over the register port as two 32-bit words, with the upper word captured at the moment the lower word is read.

Top module: `core_tick_counter`

## Requirements
- R1: After reset the control word reads 0, the prescale word reads 0x80000000, the count equals the parameter CNT_INIT (default 0), and the strobe is low.
- R2: The control word is at word address 0 (byte offset 0x000). Bit 8 and bit 9 are writable. Every other bit reads back as 0.
- R3: The prescale word is at word address 2 (byte offset 0x008). It reads back exactly as written.
- R4: With control bit 8 clear, only pulses on tick_xtal are accepted. With bit 8 set, only pulses on tick_alt are accepted. Pulses on the unselected input change nothing.
- R5: With control bit 9 clear, each counter step adds 1. With bit 9 set, each step adds 2.
- R6: Each accepted tick adds the prescale value P to a phase accumulator that holds values below 2^31. A sum of 2^31 or more produces one step and keeps the sum minus 2^31. From a cleared accumulator, N ticks therefore give floor(N*P/2^31) steps. The remainder survives a change of P.
- R7: P = 0 stops the counter. Any P above 0x80000000 acts as 0x80000000, which gives exactly one step per accepted tick.
- R8: tick_strobe is high for exactly the cycles in which the count changes. It rises on the same clock edge as the count update.
- R9: The low count word is at word address 4 and the high count word is at word address 5. Reading the low word captures the high word. A read of the high word returns the captured value. Read data appears one cycle after reg_rd and holds until the next read.
- R10: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_xtal | input | 1 | Primary tick enable, selected when control bit 8 is clear |
| tick_alt | input | 1 | Alternate tick enable, selected when control bit 8 is set |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| count | output | CNT_W | Counter value |
| tick_strobe | output | 1 | High for one cycle on each counter advance |

## Verification
The bench builds the block with CNT_INIT set to 0xFFFF_FFF0. A few ticks then carry the low word into the high word, which makes the capture of the upper word on a low-word read observable. With a zero reset value that capture could never be seen. All other parameters stay at their defaults. The full 32-bit prescaler therefore runs with fractional ratios of one half, one quarter and about two thirds, with the clamp value, and with zero.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

  localparam int REG_W    = 32;
  localparam int PS_W     = 32;

  // byte offsets of the register port
  localparam int CTRL_OFS   = 'h000;
  localparam int PS_OFS     = 'h008;
  localparam int CNT_LO_OFS = 'h010;
  localparam int CNT_HI_OFS = 'h014;

  // control word field positions
  localparam int SRC_BIT  = 8;
  localparam int STEP_BIT = 9;

  localparam logic [PS_W-1:0] PS_UNITY = 32'h8000_0000;

  typedef struct packed {
    logic step2;
    logic src_alt;
  } ctrl_t;

endpackage

// File: rtl/ctimer_rst_sync.sv
module ctimer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  generate
    if (STAGES <= 1) begin : g_single
      logic sync_q;
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
      assign rst_no = sync_q;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      logic [STAGES-1:0] sync_d;
      always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
      end
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
      end
      assign rst_no = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ctimer_regs.sv
module ctimer_regs
  import ctimer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 64
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  input  logic [CNT_W-1:0]    count,
  output ctrl_t               ctrl,
  output logic [PS_W-1:0]     prescale,
  output logic [REG_W-1:0]    rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS >> 2);
  localparam logic [ADDR_W-1:0] A_PS   = ADDR_W'(PS_OFS >> 2);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(CNT_LO_OFS >> 2);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(CNT_HI_OFS >> 2);

  ctrl_t            ctrl_q, ctrl_d;
  logic [PS_W-1:0]  ps_q, ps_d;
  logic [REG_W-1:0] hi_q, hi_d;
  logic [REG_W-1:0] rdata_q, rdata_d;
  logic             ctrl_en, ps_en, hi_en, rdata_en;
  logic [63:0]      cnt_ext;
  logic [REG_W-1:0] ctrl_word;

  assign cnt_ext = 64'(count);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[SRC_BIT]  = ctrl_q.src_alt;
    ctrl_word[STEP_BIT] = ctrl_q.step2;
  end

  // next-state: write side
  always_comb begin
    ctrl_en        = wr_en && (addr == A_CTRL);
    ps_en          = wr_en && (addr == A_PS);
    ctrl_d.src_alt = wdata[SRC_BIT];
    ctrl_d.step2   = wdata[STEP_BIT];
    ps_d           = wdata;
  end

  // next-state: read side
  always_comb begin
    rdata_en = rd_en;
    hi_en    = rd_en && (addr == A_LO);
    hi_d     = cnt_ext[63:32];
    case (addr)
      A_CTRL:  rdata_d = ctrl_word;
      A_PS:    rdata_d = ps_q;
      A_LO:    rdata_d = cnt_ext[31:0];
      A_HI:    rdata_d = hi_q;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    ps_q <= PS_UNITY;
    else if (ps_en) ps_q <= ps_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign ctrl     = ctrl_q;
  assign prescale = ps_q;
  assign rdata    = rdata_q;

endmodule

// File: rtl/ctimer_phase.sv
module ctimer_phase
  import ctimer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            tick_a,
  input  logic            tick_b,
  input  logic            src_alt,
  input  logic [PS_W-1:0] prescale,
  output logic            sel_tick,
  output logic            step
);

  localparam int PH_W = PS_W - 1;

  logic [PH_W-1:0] phase_q, phase_d;
  logic [PS_W-1:0] ps_eff;
  logic [PS_W-1:0] sum;
  logic            phase_en;

  always_comb begin
    sel_tick = src_alt ? tick_b : tick_a;
    ps_eff   = (prescale > PS_UNITY) ? PS_UNITY : prescale;
    sum      = {1'b0, phase_q} + ps_eff;
    step     = sel_tick && sum[PS_W-1];
    phase_d  = sum[PH_W-1:0];
    phase_en = sel_tick;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

endmodule

// File: rtl/ctimer_count.sv
module ctimer_count #(
  parameter int               CNT_W    = 64,
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             step,
  input  logic             step2,
  output logic [CNT_W-1:0] count,
  output logic             strobe
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             strobe_q, strobe_d;
  logic [CNT_W-1:0] amount;

  always_comb begin
    amount   = step2 ? CNT_W'(2) : CNT_W'(1);
    cnt_d    = cnt_q + amount;
    strobe_d = step;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= CNT_INIT;
    else if (step) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_d;
  end

  assign count  = cnt_q;
  assign strobe = strobe_q;

endmodule

// File: rtl/core_tick_counter.sv
module core_tick_counter
  import ctimer_pkg::*;
#(
  parameter int               ADDR_W      = 6,
  parameter int               CNT_W       = 64,
  parameter logic [CNT_W-1:0] CNT_INIT    = '0,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_xtal,
  input  logic              tick_alt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [CNT_W-1:0]  count,
  output logic              tick_strobe
);

  logic            rst_sync_n;
  ctrl_t           ctrl;
  logic [PS_W-1:0] prescale;
  logic            sel_tick;
  logic            step;
  logic            step2;

  assign step2 = ctrl.step2;

  ctimer_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  ctimer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .wr_en    (reg_wr),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .count    (count),
    .ctrl     (ctrl),
    .prescale (prescale),
    .rdata    (reg_rdata)
  );

  ctimer_phase u_phase (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .tick_a   (tick_xtal),
    .tick_b   (tick_alt),
    .src_alt  (ctrl.src_alt),
    .prescale (prescale),
    .sel_tick (sel_tick),
    .step     (step)
  );

  ctimer_count #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_count (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .step   (step),
    .step2  (step2),
    .count  (count),
    .strobe (tick_strobe)
  );

endmodule

// File: rtl/core_tick_counter_chk.sv
module core_tick_counter_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count,
  input logic             tick_strobe,
  input logic             sel_tick,
  input logic             step2,
  input logic [31:0]      prescale,
  input logic             reg_rd,
  input logic [31:0]      reg_rdata
);

  // R8: a strobe always comes with a changed count
  p_strobe_moves_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_strobe |-> (count != $past(count)));

  // R8: without a strobe the count holds
  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick_strobe |-> $stable(count));

  // R5: step size follows the control bit in force at the update edge
  p_step_size_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_strobe |-> ((count - $past(count)) == ($past(step2) ? CNT_W'(2) : CNT_W'(1))));

  // R7: zero prescale never advances the counter
  p_zero_stops_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(prescale) == 32'd0) |-> !tick_strobe);

  // R4: no accepted tick, no advance
  p_src_gate_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(sel_tick) |-> !tick_strobe);

  // R9: read data holds between reads
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(reg_rd) |-> $stable(reg_rdata));

endmodule

bind core_tick_counter core_tick_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .count       (count),
  .tick_strobe (tick_strobe),
  .sel_tick    (sel_tick),
  .step2       (step2),
  .prescale    (prescale),
  .reg_rd      (reg_rd),
  .reg_rdata   (reg_rdata)
);

// File: tb/core_tick_counter_tb.sv
module core_tick_counter_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 6;
  localparam int          CNT_W      = 64;
  localparam logic [63:0] INIT       = 64'h0000_0000_FFFF_FFF0;

  localparam logic [ADDR_W-1:0] A_CTRL = 6'd0;
  localparam logic [ADDR_W-1:0] A_PS   = 6'd2;
  localparam logic [ADDR_W-1:0] A_LO   = 6'd4;
  localparam logic [ADDR_W-1:0] A_HI   = 6'd5;
  localparam logic [ADDR_W-1:0] A_GAP  = 6'd1;
  localparam logic [ADDR_W-1:0] A_FAR  = 6'd7;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] ps;
    logic [7:0]  na;
    logic [7:0]  nb;
    logic [15:0] delta;
    logic [15:0] strobes;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h000, 32'h8000_0000, 8'd10, 8'd5, 16'd10, 16'd10}, // R4 primary source
    '{32'h100, 32'h8000_0000, 8'd10, 8'd5, 16'd5,  16'd5},  // R4 alternate source
    '{32'h200, 32'h8000_0000, 8'd7,  8'd0, 16'd14, 16'd7},  // R5 step two
    '{32'h300, 32'h4000_0000, 8'd3,  8'd8, 16'd8,  16'd4},  // R5 R6 alt, half, step two
    '{32'h000, 32'h4000_0000, 8'd9,  8'd0, 16'd4,  16'd4},  // R6 half rate
    '{32'h000, 32'h2000_0000, 8'd11, 8'd0, 16'd2,  16'd2},  // R6 quarter rate
    '{32'h000, 32'h5555_5555, 8'd9,  8'd0, 16'd5,  16'd5},  // R6 two thirds
    '{32'h000, 32'h0000_0000, 8'd6,  8'd3, 16'd0,  16'd0},  // R7 stopped
    '{32'h000, 32'hFFFF_FFFF, 8'd6,  8'd0, 16'd6,  16'd6},  // R7 clamp
    '{32'h200, 32'hC000_0000, 8'd4,  8'd0, 16'd8,  16'd4}   // R7 clamp, step two
  };

  logic              clk;
  logic              rst_n;
  logic              tick_xtal;
  logic              tick_alt;
  logic              reg_wr;
  logic              reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic [CNT_W-1:0]  count;
  logic              tick_strobe;

  int n_checks;
  int n_fail;
  int strobe_seen;

  core_tick_counter #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .CNT_INIT (INIT)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_xtal   (tick_xtal),
    .tick_alt    (tick_alt),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .count       (count),
    .tick_strobe (tick_strobe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input bit alt);
    if (alt) tick_alt = 1'b1; else tick_xtal = 1'b1;
    @(negedge clk);
    tick_alt = 1'b0; tick_xtal = 1'b0;
    if (tick_strobe) strobe_seen++;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] base;
    n_checks = 0; n_fail = 0; strobe_seen = 0;
    rst_n = 1'b0; tick_xtal = 1'b0; tick_alt = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 count", count, INIT);
    check("R1 strobe", 64'(tick_strobe), 64'd0);
    reg_read(A_CTRL, rd); check("R1 ctrl", 64'(rd), 64'h0);
    reg_read(A_PS, rd);   check("R1 prescale", 64'(rd), 64'h8000_0000);

    // R2 only bits 8 and 9 stick
    reg_write(A_CTRL, 32'hFFFF_FFFF);
    reg_read(A_CTRL, rd); check("R2 ctrl mask", 64'(rd), 64'h300);
    reg_write(A_CTRL, 32'h0);

    // R10 unmapped writes and reads
    reg_write(A_GAP, 32'h1234_5678);
    reg_write(A_FAR, 32'hDEAD_BEEF);
    reg_read(A_FAR, rd);  check("R10 unmapped read", 64'(rd), 64'h0);
    reg_read(A_GAP, rd);  check("R10 gap read", 64'(rd), 64'h0);
    reg_read(A_CTRL, rd); check("R10 ctrl untouched", 64'(rd), 64'h0);
    reg_read(A_PS, rd);   check("R10 prescale untouched", 64'(rd), 64'h8000_0000);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      do_reset();
      reg_write(A_CTRL, VECS[i].ctrl);
      reg_write(A_PS, VECS[i].ps);
      reg_read(A_CTRL, rd); check("R2 ctrl readback", 64'(rd), 64'(VECS[i].ctrl & 32'h300));
      reg_read(A_PS, rd);   check("R3 prescale readback", 64'(rd), 64'(VECS[i].ps));
      strobe_seen = 0;
      for (int k = 0; k < int'(VECS[i].na); k++) pulse(1'b0);
      for (int k = 0; k < int'(VECS[i].nb); k++) pulse(1'b1);
      check("R4 R5 R6 R7 count", count, INIT + 64'(VECS[i].delta));
      check("R8 strobe count", 64'(strobe_seen), 64'(VECS[i].strobes));
      base = INIT + 64'(VECS[i].delta);
      reg_read(A_LO, rd); check("R9 low word", 64'(rd), 64'(base[31:0]));
      reg_read(A_HI, rd); check("R9 high word", 64'(rd), 64'(base[63:32]));
    end

    // R8 strobe timing and single-cycle width
    do_reset();
    tick_xtal = 1'b1;
    @(negedge clk);
    tick_xtal = 1'b0;
    check("R8 strobe with update", 64'(tick_strobe), 64'd1);
    check("R8 count with strobe", count, INIT + 64'd1);
    @(negedge clk);
    check("R8 strobe one cycle", 64'(tick_strobe), 64'd0);

    // R4 both inputs together with alternate selected: one step only
    do_reset();
    reg_write(A_CTRL, 32'h100);
    tick_xtal = 1'b1; tick_alt = 1'b1;
    @(negedge clk);
    tick_xtal = 1'b0; tick_alt = 1'b0;
    @(negedge clk);
    tick_xtal = 1'b1;
    @(negedge clk);
    tick_xtal = 1'b0;
    @(negedge clk);
    check("R4 unselected ignored", count, INIT + 64'd1);

    // R6 remainder survives a prescale change
    do_reset();
    reg_write(A_PS, 32'h4000_0000);
    pulse(1'b0);
    reg_write(A_PS, 32'h2000_0000);
    pulse(1'b0);
    check("R6 no step at three quarters", count, INIT);
    pulse(1'b0);
    check("R6 step at whole", count, INIT + 64'd1);

    // R9 high word captured at low read
    do_reset();
    for (int k = 0; k < 10; k++) pulse(1'b0);
    reg_read(A_LO, rd); check("R9 low before carry", 64'(rd), 64'hFFFF_FFFA);
    for (int k = 0; k < 10; k++) pulse(1'b0);
    check("R9 count after carry", count, 64'h1_0000_0004);
    reg_read(A_HI, rd); check("R9 high is captured", 64'(rd), 64'h0);
    reg_read(A_LO, rd); check("R9 low after carry", 64'(rd), 64'h4);
    reg_read(A_HI, rd); check("R9 high recaptured", 64'(rd), 64'h1);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule